// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block governs one channel of a descriptor-chained transfer engine. It keeps the channel in one of three states: idle, active or paused. Software moves the channel between them by writing one-cycle command bits into an activation register. Each command is legal only in certain states. A command that does not fit the current state leaves the state alone and raises a sticky error flag. Software clears a flag by writing 1 to it.

The block also holds a configuration register. That register carries an operation mode, a source burst limit, a destination burst limit and an access-protect bit. The mode field changes only when a write explicitly asks for it. The block also holds the pointer to the next descriptor. Before a start is accepted, the pointer must be non-null and aligned as the selected mode requires.

On the datapath side, an accepted start gives a one-cycle `engineGo` pulse. `engineRun` stays high while the channel is active. The datapath reports the end of a transfer with `engineDone`, which returns an active channel to idle.

Top module: `chan_act_ctrl`

## Requirements
- R1: `chanState` reads 0 for idle, 1 for active and 2 for paused; it is idle after reset and never reads 3.
- R2: A start (activation bit 0) is accepted only in idle with a valid pointer. On the same edge the channel becomes active and `engineGo` goes high for exactly one cycle.
- R3: A start while active is refused with the busy flag (`errFlags` bit 1) and no state change. A start while paused is illegal.
- R4: Pause (activation bit 2) moves active to paused. Restart (activation bit 3) moves paused to active without an `engineGo` pulse. Both commands are illegal in any other state.
- R5: Stop (activation bit 1) moves active to idle. Stop while idle changes nothing and raises no flag. Stop while paused is illegal.
- R6: An illegal command, including a write with more than one command bit set, sets `errFlags` bit 0 and leaves the state unchanged.
- R7: Pointer rule for a start. In XOR mode (mode 1) bits [5:0] must be zero. In DMA mode (mode 0) and CRC32 mode (mode 2) bits [4:0] must be zero. A zero pointer is refused in those three modes. Memory-init mode (mode 3) does no check. A refused start sets `errFlags` bit 2 and the channel stays idle.
- R8: Configuration register layout, as seen on `cfgOut`:
  - bits [1:0] mode
  - bits [7:4] source burst limit
  - bits [11:8] destination burst limit
  - bit 12 access protect
  - The reset value is 0x0440.
  - A configuration write updates the burst and protect fields.
  - It updates the mode only when write-data bit 31 is set.
- R9: `engineDone` while active returns the channel to idle. Any command written in that same cycle is discarded and raises no flag. In idle or paused, `engineDone` has no effect.
- R10: Error flags are sticky. An activation write clears them through bits [10:8], one bit per flag. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | 0 activation, 1 configuration, 2 next-descriptor pointer, 3 unused |
| regWData | input | DATA_W | Write data |
| engineDone | input | 1 | Datapath signals end of transfer |
| chanState | output | 2 | Current channel state |
| errFlags | output | 3 | Sticky flags: bit 0 illegal, bit 1 busy, bit 2 bad pointer |
| engineGo | output | 1 | One-cycle launch pulse on an accepted start |
| engineRun | output | 1 | High while active |
| cfgOut | output | 5+2*BURST_W | Configuration register |
| nextDescPtr | output | DATA_W | Next-descriptor pointer |

## Verification
The collision that matters is a datapath completion arriving in the same cycle as a software command. The bench writes a stop together with `engineDone` while the channel is active and expects idle with no flag raised. A second collision is an error flag that is cleared in the same write that raises it. The bench provokes this with a restart while idle that also carries the clear bit, and expects the illegal flag to remain set.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2
  } chanState_e;

  typedef enum logic [1:0] {
    MODE_DMA     = 2'd0,
    MODE_XOR     = 2'd1,
    MODE_CRC     = 2'd2,
    MODE_MEMINIT = 2'd3
  } opMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setIllegal;
    logic setBusy;
    logic setPtrErr;
  } ctrlStrobe_t;

  localparam int CMD_W       = 4;
  localparam int CMD_START   = 0;
  localparam int CMD_STOP    = 1;
  localparam int CMD_PAUSE   = 2;
  localparam int CMD_RESTART = 3;
  localparam int ERR_W       = 3;
  localparam int CLR_LSB     = 8;
  localparam int ERR_ILLEGAL = 0;
  localparam int ERR_BUSY    = 1;
  localparam int ERR_PTR     = 2;
  localparam logic [1:0] SEL_ACT = 2'd0;
  localparam logic [1:0] SEL_CFG = 2'd1;
  localparam logic [1:0] SEL_PTR = 2'd2;
endpackage

// File: rtl/chan_act_fsm.sv
module chan_act_fsm
  import chan_act_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                actWr,
  input  logic [CMD_W-1:0]    cmd,
  input  logic                engineDone,
  input  logic                ptrOk,
  output chanState_e          state,
  output ctrlStrobe_t         strobe,
  output logic                engineGo
);
  chanState_e stateNext;
  logic       goNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    goNext    = 1'b0;
    if (engineDone && state == ST_ACTIVE) begin
      stateNext = ST_IDLE;
    end else if (actWr && cmd != '0) begin
      if ($countones(cmd) != 1) begin
        strobe.setIllegal = 1'b1;
      end else if (cmd[CMD_START]) begin
        case (state)
          ST_IDLE: begin
            if (ptrOk) begin
              stateNext = ST_ACTIVE;
              goNext    = 1'b1;
            end else begin
              strobe.setPtrErr = 1'b1;
            end
          end
          ST_ACTIVE: strobe.setBusy    = 1'b1;
          default:   strobe.setIllegal = 1'b1;
        endcase
      end else if (cmd[CMD_STOP]) begin
        if (state == ST_ACTIVE)      stateNext = ST_IDLE;
        else if (state == ST_PAUSED) strobe.setIllegal = 1'b1;
      end else if (cmd[CMD_PAUSE]) begin
        if (state == ST_ACTIVE) stateNext = ST_PAUSED;
        else                    strobe.setIllegal = 1'b1;
      end else begin
        if (state == ST_PAUSED) stateNext = ST_ACTIVE;
        else                    strobe.setIllegal = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      engineGo <= 1'b0;
    end else begin
      state    <= stateNext;
      engineGo <= goNext;
    end
  end
endmodule

// File: rtl/chan_act_regs.sv
module chan_act_regs
  import chan_act_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BURST_W   = 4,
  parameter int BURST_RST = 4,
  parameter int XOR_ALIGN = 6,
  parameter int DMA_ALIGN = 5,
  localparam int CFG_W    = 5 + 2 * BURST_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               actWr,
  input  logic               cfgWr,
  input  logic               ptrWr,
  input  logic [DATA_W-1:0]  wData,
  input  ctrlStrobe_t        strobe,
  output logic               ptrOk,
  output logic [ERR_W-1:0]   errFlags,
  output logic [CFG_W-1:0]   cfgOut,
  output logic [DATA_W-1:0]  nextDescPtr
);
  localparam int SRC_LSB  = 4;
  localparam int DST_LSB  = SRC_LSB + BURST_W;
  localparam int PROT_BIT = DST_LSB + BURST_W;
  localparam int MODE_WE  = DATA_W - 1;

  opMode_e            mode;
  logic [BURST_W-1:0] srcBurst, dstBurst;
  logic               protect;
  logic [ERR_W-1:0]   setMask, clrMask;

  always_comb begin
    case (mode)
      MODE_XOR:     ptrOk = (nextDescPtr != '0) && (nextDescPtr[XOR_ALIGN-1:0] == '0);
      MODE_MEMINIT: ptrOk = 1'b1;
      default:      ptrOk = (nextDescPtr != '0) && (nextDescPtr[DMA_ALIGN-1:0] == '0);
    endcase
  end

  always_comb begin
    setMask = '0;
    setMask[ERR_ILLEGAL] = strobe.setIllegal;
    setMask[ERR_BUSY]    = strobe.setBusy;
    setMask[ERR_PTR]     = strobe.setPtrErr;
    clrMask = actWr ? wData[CLR_LSB +: ERR_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_DMA;
      srcBurst    <= BURST_W'(BURST_RST);
      dstBurst    <= BURST_W'(BURST_RST);
      protect     <= 1'b0;
      nextDescPtr <= '0;
      errFlags    <= '0;
    end else begin
      errFlags <= (errFlags & ~clrMask) | setMask;
      if (cfgWr) begin
        srcBurst <= wData[SRC_LSB +: BURST_W];
        dstBurst <= wData[DST_LSB +: BURST_W];
        protect  <= wData[PROT_BIT];
        if (wData[MODE_WE]) mode <= opMode_e'(wData[1:0]);
      end
      if (ptrWr) nextDescPtr <= wData;
    end
  end

  assign cfgOut = {protect, dstBurst, srcBurst, 2'b00, mode};
endmodule

// File: rtl/chan_act_ctrl.sv
module chan_act_ctrl
  import chan_act_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BURST_W   = 4,
  parameter int BURST_RST = 4,
  parameter int XOR_ALIGN = 6,
  parameter int DMA_ALIGN = 5,
  localparam int CFG_W    = 5 + 2 * BURST_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWData,
  input  logic              engineDone,
  output logic [1:0]        chanState,
  output logic [ERR_W-1:0]  errFlags,
  output logic              engineGo,
  output logic              engineRun,
  output logic [CFG_W-1:0]  cfgOut,
  output logic [DATA_W-1:0] nextDescPtr
);
  logic        actWr, cfgWr, ptrWr, ptrOk;
  chanState_e  state;
  ctrlStrobe_t strobe;

  assign actWr = regWr && regSel == SEL_ACT;
  assign cfgWr = regWr && regSel == SEL_CFG;
  assign ptrWr = regWr && regSel == SEL_PTR;

  chan_act_fsm u_fsm (
    .clk(clk), .rstN(rstN), .actWr(actWr), .cmd(regWData[CMD_W-1:0]),
    .engineDone(engineDone), .ptrOk(ptrOk), .state(state),
    .strobe(strobe), .engineGo(engineGo)
  );

  chan_act_regs #(
    .DATA_W(DATA_W), .BURST_W(BURST_W), .BURST_RST(BURST_RST),
    .XOR_ALIGN(XOR_ALIGN), .DMA_ALIGN(DMA_ALIGN)
  ) u_regs (
    .clk(clk), .rstN(rstN), .actWr(actWr), .cfgWr(cfgWr), .ptrWr(ptrWr),
    .wData(regWData), .strobe(strobe), .ptrOk(ptrOk), .errFlags(errFlags),
    .cfgOut(cfgOut), .nextDescPtr(nextDescPtr)
  );

  assign chanState = state;
  assign engineRun = (state == ST_ACTIVE);
endmodule

// File: rtl/chan_act_chk.sv
module chan_act_chk #(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] regWData,
  input logic              engineDone,
  input logic [1:0]        chanState,
  input logic [2:0]        errFlags,
  input logic              engineGo,
  input logic [CFG_W-1:0]  cfgOut
);
  AST_NO_STATE3: assert property (@(posedge clk) disable iff (!rstN)
    chanState != 2'd3); // R1

  AST_IDLE_TO_ACTIVE_GO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chanState) == 2'd0 && chanState == 2'd1) |-> engineGo); // R2

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    engineGo |=> !engineGo); // R2

  AST_PAUSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (chanState == 2'd2 && $past(chanState) != 2'd2) |-> $past(chanState) == 2'd1); // R4

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (engineDone && chanState == 2'd1) |=> chanState == 2'd0); // R9

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 2'd1 && !regWData[DATA_W-1]) |=> $stable(cfgOut[1:0])); // R8

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags[0] && !(regWr && regSel == 2'd0 && regWData[8])) |=> errFlags[0]); // R10
endmodule

bind chan_act_ctrl chan_act_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWData(regWData),
  .engineDone(engineDone), .chanState(chanState), .errFlags(errFlags),
  .engineGo(engineGo), .cfgOut(cfgOut)
);

// File: tb/chan_act_ctrl_tb.sv
module chan_act_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWData = '0;
  logic        engineDone = 1'b0;
  logic [1:0]  chanState;
  logic [2:0]  errFlags;
  logic        engineGo, engineRun;
  logic [12:0] cfgOut;
  logic [31:0] nextDescPtr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]  st;
    logic [2:0]  er;
    logic        go;
    logic [12:0] cfg;
    string       tag;
    int          stamp;
  } exp_t;
  exp_t q[$];

  chan_act_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWData(regWData),
    .engineDone(engineDone), .chanState(chanState), .errFlags(errFlags),
    .engineGo(engineGo), .engineRun(engineRun), .cfgOut(cfgOut),
    .nextDescPtr(nextDescPtr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares scoreboard items due this cycle
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (chanState !== e.st || errFlags !== e.er || engineGo !== e.go ||
          cfgOut !== e.cfg || engineRun !== (e.st == 2'd1)) begin
        fails++;
        $display("FAIL %s: state=%0d err=%b go=%b cfg=%h expected state=%0d err=%b go=%b cfg=%h",
                 e.tag, chanState, errFlags, engineGo, cfgOut, e.st, e.er, e.go, e.cfg);
      end
    end
  end

  task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                      input logic done, input logic [1:0] st, input logic [2:0] er,
                      input logic go, input logic [12:0] cfg, input string tag);
    exp_t e;
    regWr = wr; regSel = sel; regWData = d; engineDone = done;
    e.st = st; e.er = er; e.go = go; e.cfg = cfg; e.tag = tag; e.stamp = cyc + 1;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  localparam logic [12:0] C0 = 13'h0440;
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 3'b000, 0, C0, "R1 reset state");
    step(1, 0, 32'h1, 0, 0, 3'b100, 0, C0, "R7 null pointer start");
    step(1, 0, 32'h400, 0, 0, 3'b000, 0, C0, "R10 clear pointer flag");
    step(1, 2, 32'h1010, 0, 0, 3'b000, 0, C0, "R7 pointer write");
    step(1, 0, 32'h1, 0, 0, 3'b100, 0, C0, "R7 DMA misaligned");
    step(1, 0, 32'h700, 0, 0, 3'b000, 0, C0, "R10 clear all");
    step(1, 2, 32'h1020, 0, 0, 3'b000, 0, C0, "R7 pointer write aligned");
    step(1, 0, 32'h1, 0, 1, 3'b000, 1, C0, "R2 start accepted");
    step(0, 0, 0, 0, 1, 3'b000, 0, C0, "R2 go single pulse");
    step(1, 0, 32'h1, 0, 1, 3'b010, 0, C0, "R3 start while active busy");
    step(1, 0, 32'h4, 0, 2, 3'b010, 0, C0, "R4 pause");
    step(1, 0, 32'h4, 0, 2, 3'b011, 0, C0, "R6 pause while paused");
    step(1, 0, 32'h2, 0, 2, 3'b011, 0, C0, "R5 stop while paused");
    step(1, 0, 32'h1, 0, 2, 3'b011, 0, C0, "R3 start while paused");
    step(1, 0, 32'h300, 0, 2, 3'b000, 0, C0, "R10 clear two flags");
    step(1, 0, 32'h8, 0, 1, 3'b000, 0, C0, "R4 restart no go");
    step(1, 0, 32'h2, 1, 0, 3'b000, 0, C0, "R9 done with stop same cycle");
    step(1, 0, 32'h2, 0, 0, 3'b000, 0, C0, "R5 stop while idle no-op");
    step(1, 0, 32'h108, 0, 0, 3'b001, 0, C0, "R10 set wins over clear");
    step(1, 0, 32'h100, 0, 0, 3'b000, 0, C0, "R10 clear illegal");
    step(1, 0, 32'h3, 0, 0, 3'b001, 0, C0, "R6 two command bits");
    step(1, 0, 32'h100, 0, 0, 3'b000, 0, C0, "R10 clear");
    step(1, 1, 32'h1893, 0, 0, 3'b000, 0, 13'h1890, "R8 mode kept");
    step(1, 1, 32'h8000_0441, 0, 0, 3'b000, 0, 13'h0441, "R8 mode to XOR");
    step(1, 0, 32'h1, 0, 0, 3'b100, 0, 13'h0441, "R7 XOR needs 64-byte");
    step(1, 0, 32'h400, 0, 0, 3'b000, 0, 13'h0441, "R10 clear");
    step(1, 2, 32'h1040, 0, 0, 3'b000, 0, 13'h0441, "R7 pointer write");
    step(1, 0, 32'h1, 0, 1, 3'b000, 1, 13'h0441, "R7 XOR aligned start");
    step(0, 0, 0, 1, 0, 3'b000, 0, 13'h0441, "R9 done to idle");
    step(0, 0, 0, 1, 0, 3'b000, 0, 13'h0441, "R9 done in idle ignored");
    step(1, 1, 32'h8000_0442, 0, 0, 3'b000, 0, 13'h0442, "R8 mode to CRC");
    step(1, 2, 32'h1010, 0, 0, 3'b000, 0, 13'h0442, "R7 pointer write");
    step(1, 0, 32'h1, 0, 0, 3'b100, 0, 13'h0442, "R7 CRC misaligned");
    step(1, 0, 32'h400, 0, 0, 3'b000, 0, 13'h0442, "R10 clear");
    step(1, 1, 32'h8000_0443, 0, 0, 3'b000, 0, 13'h0443, "R8 mode to meminit");
    step(1, 2, 32'h0, 0, 0, 3'b000, 0, 13'h0443, "R7 null pointer write");
    step(1, 0, 32'h1, 0, 1, 3'b000, 1, 13'h0443, "R7 meminit skips check");
    step(1, 0, 32'h4, 0, 2, 3'b000, 0, 13'h0443, "R4 pause");
    step(0, 0, 0, 1, 2, 3'b000, 0, 13'h0443, "R9 done while paused ignored");
    step(1, 0, 32'h8, 0, 1, 3'b000, 0, 13'h0443, "R4 restart");
    step(1, 0, 32'h2, 0, 0, 3'b000, 0, 13'h0443, "R5 stop from active");
    step(0, 0, 0, 0, 0, 3'b000, 0, 13'h0443, "R1 idle settles");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    finish_run();
  end
endmodule